// File: doc/BRIEF.md
# Stateful Pattern Word Compressor

This block compresses a 512-bit cache line into a variable-length bitstream. The line is cut into sixteen 32-bit words. Each word is tested against a fixed set of value patterns and against the two words that come before it in the same line. The word then receives the 4-bit code whose payload is narrowest. The result is a 64-bit header that holds all sixteen codes, followed by the payloads of the words packed back to back with no gaps.

A caller offers a line with a valid/ready handshake, together with a bit budget and an overhead figure. Four classifier lanes code four words per cycle, so the whole line is coded in four cycles. A packing stage then computes a running sum of the payload widths and places every payload. The block returns the stream, its length in bits, and a flag that tells whether the stream plus the overhead fits in the budget. The caller uses that flag to decide whether the line can share storage with another line.

Top module: `linepack_top`

## Requirements
- R1: `in_ready` is high exactly when the block is idle. A line is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low on the cycle after a line is taken.
- R2: `out_valid` is a one-cycle pulse that rises on the fifth clock edge after the edge that took the line. `in_ready` is high during that pulse.
- R3: Code numbers and payload widths in bits are as follows. 0 = zero word (0). 1 = equal to the previous word (0). 2 = equal to the second-previous word (0). 3 = fits in 4 signed bits (4). 4 = fits in 8 signed bits (8). 5 = fits in 16 signed bits (16). 6 = upper half zero (16). 7 = lower half zero (16). 8 = each half is a sign-extended byte (16). 9 = all four bytes equal (8). 10 = upper 16 bits equal to those of the previous word (16). 11 = upper 24 bits equal to those of the previous word (8). 12 = upper 16 bits equal to those of the second-previous word (16). 13 = upper 24 bits equal to those of the second-previous word (8). 15 = raw (32). Among the codes that apply, the narrowest payload wins, and a tie goes to the lower code number.
- R4: History is kept within one line only. For word 0 both history entries read as zero. For word 1 the second-previous entry reads as zero. Words from an earlier line never act as history.
- R5: In the stream, the code of word i sits at bits [4i+3:4i].
- R6: The payload of word i begins at bit 64 plus the sum of the payload widths of words 0 to i-1, least significant bit first. For each code the payload holds the following bits of the word. Code 3: bits [3:0]. Codes 4, 9, 11 and 13: bits [7:0]. Codes 5, 6, 10 and 12: bits [15:0]. Code 7: bits [31:16]. Code 8: bits [23:16] above bits [7:0]. Code 15: the whole word.
- R7: Every stream bit at or above `out_len` is zero.
- R8: `out_len` equals 64 plus the sum of the sixteen payload widths.
- R9: `out_fits` is high exactly when `out_len` plus the overhead taken with the line is at most the budget taken with the line.
- R10: After reset, `out_valid` is low, `in_ready` is high, and the stream, length and fits outputs are zero.
- R11: Code 14 is reserved and never appears in the header.
- R12: The stream, length and fits outputs hold their values between pulses of `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A line is offered |
| in_ready | output | 1 | Block is idle and will take a line |
| in_line | input | 512 | Line; word i occupies bits [32i+31:32i] |
| in_budget | input | BUDGET_W (11) | Bit budget for the compressed line |
| in_overhead | input | BUDGET_W (11) | Extra bits added to the length before the budget compare |
| out_valid | output | 1 | One-cycle result pulse |
| out_stream | output | 576 | Header and packed payloads |
| out_len | output | 10 | Stream length in bits |
| out_fits | output | 1 | Length plus overhead is within budget |

## Verification
The bench goes after the corner cases in code choice. When two codes tie on width, a design that checked the codes in the wrong order would emit the higher code, for example 12 instead of 5 for 0xFFFF8000, and the header would differ from the reference. Directed lines cover the empty history of words 0 and 1. They also cover a line whose first word repeats the last word of the line before it, so a design that carried history across lines would code that word as a repeat instead of raw. The bench sets the budget one below, exactly at, and one above the needed size. An off-by-one compare would flip `out_fits` at the exact boundary. Random lines made from every pattern kind, offered with gaps and back to back, would expose a wrong payload offset as misplaced bits, stray bits above the length, or a pulse on the wrong cycle.

// File: rtl/linepack_pkg.sv
// Shared constants, the code set and the per-code payload rules.
// Assumes a fixed word width of 32 bits and a 4-bit code per word.
package linepack_pkg;
    localparam int WORD_W   = 32;
    localparam int N_WORDS  = 16;
    localparam int CODE_W   = 4;
    localparam int LINE_W   = WORD_W * N_WORDS;
    localparam int HDR_W    = CODE_W * N_WORDS;
    localparam int STREAM_W = HDR_W + LINE_W;
    localparam int LEN_W    = $clog2(STREAM_W + 1);
    localparam int PW_W     = $clog2(WORD_W + 1);

    typedef enum logic [CODE_W-1:0] {
        C_ZERO     = 4'd0,
        C_PREV     = 4'd1,
        C_PREV2    = 4'd2,
        C_SE4      = 4'd3,
        C_SE8      = 4'd4,
        C_SE16     = 4'd5,
        C_HI_ZERO  = 4'd6,
        C_LO_ZERO  = 4'd7,
        C_HALFBYTE = 4'd8,
        C_REPBYTE  = 4'd9,
        C_P1_HI16  = 4'd10,
        C_P1_HI24  = 4'd11,
        C_P2_HI16  = 4'd12,
        C_P2_HI24  = 4'd13,
        C_RESERVED = 4'd14,
        C_RAW      = 4'd15
    } code_e;

    // Payload width in bits for a code.
    function automatic logic [PW_W-1:0] pay_width(code_e c);
        case (c)
            C_ZERO, C_PREV, C_PREV2:                  return PW_W'(0);
            C_SE4:                                    return PW_W'(4);
            C_SE8, C_REPBYTE, C_P1_HI24, C_P2_HI24:   return PW_W'(8);
            C_RESERVED, C_RAW:                        return PW_W'(32);
            default:                                  return PW_W'(16);
        endcase
    endfunction

    // Payload bits for a code, right aligned, zero above the width.
    function automatic logic [WORD_W-1:0] pay_bits(code_e c, logic [WORD_W-1:0] w);
        case (c)
            C_ZERO, C_PREV, C_PREV2:                  return '0;
            C_SE4:                                    return {28'h0, w[3:0]};
            C_SE8, C_REPBYTE, C_P1_HI24, C_P2_HI24:   return {24'h0, w[7:0]};
            C_LO_ZERO:                                return {16'h0, w[31:16]};
            C_HALFBYTE:                               return {16'h0, w[23:16], w[7:0]};
            C_RESERVED, C_RAW:                        return w;
            default:                                  return {16'h0, w[15:0]};
        endcase
    endfunction
endpackage

// File: rtl/word_classifier.sv
// Chooses the code for one word given the two words before it.
// Purely combinational. Assumes missing history is presented as zero.
module word_classifier
    import linepack_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] prev1,
    input  logic [WORD_W-1:0] prev2,
    output logic [CODE_W-1:0] code
);
    logic [15:0] hit;

    // Evaluate every pattern against the word and its history.
    always_comb begin
        hit = '0;
        hit[C_ZERO]     = (cur == '0);
        hit[C_PREV]     = (cur == prev1);
        hit[C_PREV2]    = (cur == prev2);
        hit[C_SE4]      = (cur[31:3] == '0) || (cur[31:3] == '1);
        hit[C_SE8]      = (cur[31:7] == '0) || (cur[31:7] == '1);
        hit[C_SE16]     = (cur[31:15] == '0) || (cur[31:15] == '1);
        hit[C_HI_ZERO]  = (cur[31:16] == '0);
        hit[C_LO_ZERO]  = (cur[15:0] == '0);
        hit[C_HALFBYTE] = ((cur[31:23] == '0) || (cur[31:23] == '1)) &&
                          ((cur[15:7] == '0) || (cur[15:7] == '1));
        hit[C_REPBYTE]  = (cur[31:8] == {cur[7:0], cur[7:0], cur[7:0]});
        hit[C_P1_HI16]  = (cur[31:16] == prev1[31:16]);
        hit[C_P1_HI24]  = (cur[31:8] == prev1[31:8]);
        hit[C_P2_HI16]  = (cur[31:16] == prev2[31:16]);
        hit[C_P2_HI24]  = (cur[31:8] == prev2[31:8]);
        hit[C_RESERVED] = 1'b0;
        hit[C_RAW]      = 1'b1;
    end

    // Pick the narrowest applicable code; ascending scan keeps the lowest on ties.
    always_comb begin
        logic [PW_W-1:0] best_w;
        code   = C_RAW;
        best_w = pay_width(C_RAW);
        for (int c = 0; c < 16; c++) begin
            if (hit[c] && (pay_width(code_e'(4'(c))) < best_w)) begin
                code   = 4'(c);
                best_w = pay_width(code_e'(4'(c)));
            end
        end
    end
endmodule

// File: rtl/stream_packer.sv
// Builds the header and the packed payload area from the stored codes.
// Combinational running sum of payload widths. Assumes codes never take the
// reserved value, so every payload has its intended width.
module stream_packer
    import linepack_pkg::*;
(
    input  logic [HDR_W-1:0]    hdr,
    input  logic [LINE_W-1:0]   line,
    output logic [STREAM_W-1:0] stream,
    output logic [LEN_W-1:0]    len
);
    // Place each payload at the running offset and accumulate the length.
    always_comb begin
        logic [LEN_W-1:0]  off;
        code_e             c;
        logic [WORD_W-1:0] pb;
        stream            = '0;
        stream[HDR_W-1:0] = hdr;
        off               = LEN_W'(HDR_W);
        for (int i = 0; i < N_WORDS; i++) begin
            c      = code_e'(hdr[i*CODE_W +: CODE_W]);
            pb     = pay_bits(c, line[i*WORD_W +: WORD_W]);
            stream = stream | (STREAM_W'(pb) << off);
            off    = off + LEN_W'(pay_width(c));
        end
        len = off;
    end
endmodule

// File: rtl/linepack_top.sv
// Line compressor top: takes a line, codes LANES words per cycle, then packs.
// Sequence: IDLE -> CLASS (N_WORDS/LANES cycles) -> PACK (1 cycle) -> IDLE.
// Assumes LANES divides N_WORDS and BUDGET_W >= LEN_W.
module linepack_top
    import linepack_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int BUDGET_W = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [LINE_W-1:0]   in_line,
    input  logic [BUDGET_W-1:0] in_budget,
    input  logic [BUDGET_W-1:0] in_overhead,
    output logic                out_valid,
    output logic [STREAM_W-1:0] out_stream,
    output logic [LEN_W-1:0]    out_len,
    output logic                out_fits
);
    localparam int N_GROUPS = N_WORDS / LANES;
    localparam int PH_W     = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
    localparam int SUM_W    = BUDGET_W + 1;

    typedef enum logic [1:0] {ST_IDLE, ST_CLASS, ST_PACK} state_e;

    state_e                state_q;
    logic [PH_W-1:0]       phase_q;
    logic [LINE_W-1:0]     line_q;
    logic [BUDGET_W-1:0]   budget_q;
    logic [BUDGET_W-1:0]   ovh_q;
    logic [HDR_W-1:0]      hdr_q;
    logic                  accept;
    logic [CODE_W-1:0]     lane_code [LANES];
    logic [STREAM_W-1:0]   pk_stream;
    logic [LEN_W-1:0]      pk_len;
    logic [SUM_W-1:0]      need;
    logic                  pk_fits;

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = in_valid && in_ready;

    // One classifier per lane, fed with its word and two history words.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [WORD_W-1:0] cur, p1, p2;

        // Select the lane's word and its in-line history; absent history reads zero.
        always_comb begin
            int idx, i1, i2;
            idx = int'(phase_q) * LANES + l;
            i1  = (idx >= 1) ? idx - 1 : 0;
            i2  = (idx >= 2) ? idx - 2 : 0;
            cur = line_q[idx*WORD_W +: WORD_W];
            p1  = (idx >= 1) ? line_q[i1*WORD_W +: WORD_W] : '0;
            p2  = (idx >= 2) ? line_q[i2*WORD_W +: WORD_W] : '0;
        end

        word_classifier u_cls (
            .cur   (cur),
            .prev1 (p1),
            .prev2 (p2),
            .code  (lane_code[l])
        );
    end

    stream_packer u_pack (
        .hdr    (hdr_q),
        .line   (line_q),
        .stream (pk_stream),
        .len    (pk_len)
    );

    // Budget compare on the packed length plus the caller's overhead.
    always_comb begin
        need    = SUM_W'(pk_len) + SUM_W'(ovh_q);
        pk_fits = (need <= SUM_W'(budget_q));
    end

    // Sequencer: capture, step through the word groups, then hand to packing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE:  if (accept) begin
                              state_q <= ST_CLASS;
                              phase_q <= '0;
                          end
                ST_CLASS: begin
                              if (phase_q == PH_W'(N_GROUPS - 1)) state_q <= ST_PACK;
                              phase_q <= phase_q + 1'b1;
                          end
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Input capture of the line, budget and overhead on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q   <= '0;
            budget_q <= '0;
            ovh_q    <= '0;
        end else if (accept) begin
            line_q   <= in_line;
            budget_q <= in_budget;
            ovh_q    <= in_overhead;
        end
    end

    // Store the codes of the current word group into the header register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
        end else if (state_q == ST_CLASS) begin
            for (int l = 0; l < LANES; l++) begin
                hdr_q[(int'(phase_q) * LANES + l) * CODE_W +: CODE_W] <= lane_code[l];
            end
        end
    end

    // Result register: loaded in the pack state, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_stream <= '0;
            out_len    <= '0;
            out_fits   <= 1'b0;
        end else begin
            out_valid <= (state_q == ST_PACK);
            if (state_q == ST_PACK) begin
                out_stream <= pk_stream;
                out_len    <= pk_len;
                out_fits   <= pk_fits;
            end
        end
    end
endmodule

// File: rtl/linepack_chk.sv
// Protocol and output checker for linepack_top, attached with bind.
// Keeps its own copy of the budget terms and an edge counter since acceptance.
module linepack_chk
    import linepack_pkg::*;
#(
    parameter int BUDGET_W = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic [BUDGET_W-1:0] in_budget,
    input logic [BUDGET_W-1:0] in_overhead,
    input logic                out_valid,
    input logic [STREAM_W-1:0] out_stream,
    input logic [LEN_W-1:0]    out_len,
    input logic                out_fits
);
    logic [2:0]          since_q;
    logic [BUDGET_W-1:0] bud_q, ovh_q;
    logic                rsvd_seen;

    // Count clock edges since the last acceptance, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= 3'd7;
            bud_q   <= '0;
            ovh_q   <= '0;
        end else if (in_valid && in_ready) begin
            since_q <= 3'd0;
            bud_q   <= in_budget;
            ovh_q   <= in_overhead;
        end else if (since_q != 3'd7) begin
            since_q <= since_q + 3'd1;
        end
    end

    // Scan the emitted header for the reserved code.
    always_comb begin
        rsvd_seen = 1'b0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (out_stream[i*CODE_W +: CODE_W] == C_RESERVED) rsvd_seen = 1'b1;
        end
    end

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready); // R1
    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (since_q == 3'd5)); // R2
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R2
    AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> in_ready); // R2
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= LEN_W'(HDR_W)) && (out_len <= LEN_W'(STREAM_W))); // R8
    AST_FITS_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_fits == ((BUDGET_W+1)'(out_len) + (BUDGET_W+1)'(ovh_q) <= (BUDGET_W+1)'(bud_q)))); // R9
    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !rsvd_seen); // R11
    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_len) && $stable(out_stream) && $stable(out_fits))); // R12
endmodule

bind linepack_top linepack_chk #(.BUDGET_W(BUDGET_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_budget   (in_budget),
    .in_overhead (in_overhead),
    .out_valid   (out_valid),
    .out_stream  (out_stream),
    .out_len     (out_len),
    .out_fits    (out_fits)
);

// File: tb/tb_linepack_top.sv
`timescale 1ns/1ps
module tb_linepack_top;
    localparam int NLINES = 160;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [511:0]  in_line = '0;
    logic [10:0]   in_budget = '0;
    logic [10:0]   in_overhead = '0;
    logic          out_valid;
    logic [575:0]  out_stream;
    logic [9:0]    out_len;
    logic          out_fits;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    linepack_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .in_budget(in_budget), .in_overhead(in_overhead),
        .out_valid(out_valid), .out_stream(out_stream), .out_len(out_len),
        .out_fits(out_fits)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [575:0] act, input logic [575:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic int ref_width(int c);
        case (c)
            0, 1, 2:        return 0;
            3:              return 4;
            4, 9, 11, 13:   return 8;
            14, 15:         return 32;
            default:        return 16;
        endcase
    endfunction

    function automatic bit ref_applies(int c, bit [31:0] w, bit [31:0] p, bit [31:0] q);
        int s;
        shortint hi, lo;
        s  = $signed(w);
        hi = w[31:16];
        lo = w[15:0];
        case (c)
            0:  return w == 0;
            1:  return w == p;
            2:  return w == q;
            3:  return s >= -8 && s <= 7;
            4:  return s >= -128 && s <= 127;
            5:  return s >= -32768 && s <= 32767;
            6:  return w[31:16] == 0;
            7:  return w[15:0] == 0;
            8:  return hi >= -128 && hi <= 127 && lo >= -128 && lo <= 127;
            9:  return w[31:24] == w[7:0] && w[23:16] == w[7:0] && w[15:8] == w[7:0];
            10: return w[31:16] == p[31:16];
            11: return w[31:8] == p[31:8];
            12: return w[31:16] == q[31:16];
            13: return w[31:8] == q[31:8];
            14: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic bit [31:0] ref_payload(int c, bit [31:0] w);
        case (c)
            3:              return w & 32'hF;
            4, 9, 11, 13:   return w & 32'hFF;
            7:              return w >> 16;
            8:              return {16'h0, w[23:16], w[7:0]};
            0, 1, 2:        return 0;
            14, 15:         return w;
            default:        return w & 32'hFFFF;
        endcase
    endfunction

    task automatic ref_compress(input bit [511:0] line, output bit [575:0] st, output int len);
        int pos;
        st  = '0;
        pos = 64;
        for (int i = 0; i < 16; i++) begin
            bit [31:0] w, p, q, pl;
            int best;
            w = line[i*32 +: 32];
            p = (i >= 1) ? line[(i-1)*32 +: 32] : 32'h0;
            q = (i >= 2) ? line[(i-2)*32 +: 32] : 32'h0;
            best = 15;
            for (int c = 14; c >= 0; c--)
                if (ref_applies(c, w, p, q) && ref_width(c) <= ref_width(best)) best = c;
            st[i*4 +: 4] = best[3:0];
            pl = ref_payload(best, w);
            for (int b = 0; b < ref_width(best); b++) begin
                st[pos] = pl[b];
                pos++;
            end
        end
        len = pos;
    endtask

    // ---------------- stimulus ----------------
    function automatic bit [31:0] rand_word(bit [31:0] p, bit [31:0] q);
        bit [31:0] r;
        r = $urandom;
        case ($urandom % 15)
            0:  return 0;
            1:  return p;
            2:  return q;
            3:  return 32'($signed(4'(r)));
            4:  return 32'($signed(8'(r)));
            5:  return 32'($signed(16'(r)));
            6:  return {16'h0, r[15:0]};
            7:  return {r[15:0], 16'h0};
            8:  return {{8{r[15]}}, r[15:8], {8{r[7]}}, r[7:0]};
            9:  return {4{r[7:0]}};
            10: return {p[31:16], r[15:0]};
            11: return {p[31:8], r[7:0]};
            12: return {q[31:16], r[15:0]};
            13: return {q[31:8], r[7:0]};
            default: return r;
        endcase
    endfunction

    function automatic bit [511:0] gen_line(int n);
        bit [511:0] l;
        bit [31:0] d2 [16];
        l = '0;
        d2 = '{32'hFFFFFFF9, 32'h0000007F, 32'hFFFF8000, 32'h12340000,
               32'h0000ABCD, 32'h007FFF80, 32'h5A5A5A5A, 32'h5A5AC3C3,
               32'h5A5AC3E1, 32'h11112222, 32'h5A5AC3FF, 32'h11119999,
               32'h0, 32'h0, 32'h0, 32'h87654321};
        case (n)
            0: l = '0;
            1: begin
                l[31:0]  = 32'h12345678; l[63:32]  = 32'h12345678;
                l[95:64] = 32'h9ABCDEF0; l[127:96] = 32'h12345678;
            end
            2: for (int i = 0; i < 16; i++) l[i*32 +: 32] = d2[i];
            3: l[31:0] = 32'h87654321;
            default: for (int i = 0; i < 16; i++)
                l[i*32 +: 32] = rand_word(i >= 1 ? l[(i-1)*32 +: 32] : 32'h0,
                                          i >= 2 ? l[(i-2)*32 +: 32] : 32'h0);
        endcase
        return l;
    endfunction

    // ---------------- main loop ----------------
    initial begin
        bit [575:0] cur_st, fl_st, pd_st;
        int cur_len, fl_len, pd_len;
        bit cur_fits, fl_fits, pd_fits;
        int cur_idx, fl_idx;
        int rem, line_idx, cyc;
        bit exp_vld, have_pend, done;
        bit [3:0] d2_codes [16];
        d2_codes = '{4'd3, 4'd4, 4'd5, 4'd7, 4'd6, 4'd8, 4'd9, 4'd10,
                     4'd11, 4'd15, 4'd13, 4'd12, 4'd0, 4'd0, 4'd0, 4'd15};
        cur_st = '0; cur_len = 0; cur_fits = 0; cur_idx = -1; fl_idx = -1;
        fl_st = '0; fl_len = 0; fl_fits = 0; pd_st = '0; pd_len = 0; pd_fits = 0;
        rem = 0; line_idx = 0; cyc = 0; exp_vld = 0; have_pend = 0; done = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        while (!done) begin
            @(negedge clk);
            cyc++;
            // compare every output with the model each cycle (R1 R2 R10 R12)
            chk(in_ready == (rem == 0), "R1", "in_ready", 576'(in_ready), 576'(rem == 0));
            chk(out_valid == exp_vld, "R2", "out_valid", 576'(out_valid), 576'(exp_vld));
            chk(out_stream[63:0] == cur_st[63:0], "R3 R4 R5", "header", 576'(out_stream[63:0]), 576'(cur_st[63:0]));
            chk(out_stream == cur_st, "R6 R7 R12", "stream", out_stream, cur_st);
            chk(int'(out_len) == cur_len, "R8 R12", "length", 576'(out_len), 576'(cur_len));
            chk(out_fits == cur_fits, "R9 R12", "fits", 576'(out_fits), 576'(cur_fits));
            if (cyc == 1) begin
                // R10: post-reset state
                chk(!out_valid && in_ready && out_len == 0 && out_stream == 0 && !out_fits,
                    "R10", "reset state", 576'(out_len), 576'(0));
            end
            if (exp_vld) begin
                // R11: reserved code never emitted
                for (int i = 0; i < 16; i++)
                    chk(out_stream[i*4 +: 4] != 4'd14, "R11", "reserved code", 576'(out_stream[i*4 +: 4]), 576'(0));
                if (cur_idx == 0)
                    chk(out_len == 10'd64 && out_stream == 0, "R3 R8", "zero line", 576'(out_len), 576'(64));
                if (cur_idx == 1)
                    chk(out_stream[15:0] == 16'h2F1F, "R4", "history codes", 576'(out_stream[15:0]), 576'(16'h2F1F));
                if (cur_idx == 2) begin
                    for (int i = 0; i < 16; i++)
                        chk(out_stream[i*4 +: 4] == d2_codes[i], "R3", "pattern code", 576'(out_stream[i*4 +: 4]), 576'(d2_codes[i]));
                    chk(out_len == 10'd260, "R8", "pattern length", 576'(out_len), 576'(260));
                end
                if (cur_idx == 3)
                    chk(out_stream[3:0] == 4'd15, "R4", "no cross-line history", 576'(out_stream[3:0]), 576'(15));
            end

            // prepare the next line with its expected result
            if (!have_pend && line_idx < NLINES) begin
                int ov, bud;
                bit [511:0] l;
                l = gen_line(line_idx);
                ref_compress(l, pd_st, pd_len);
                ov = $urandom % 16;
                case (line_idx % 4)
                    0: bud = pd_len + ov - 1;
                    1: bud = pd_len + ov;
                    2: bud = pd_len + ov + 1;
                    default: bud = $urandom % 700;
                endcase
                if (bud < 0) bud = 0;
                pd_fits = (pd_len + ov) <= bud;
                in_line = l; in_budget = 11'(bud); in_overhead = 11'(ov);
                have_pend = 1;
            end
            in_valid = have_pend && (($urandom % 4) != 0 || line_idx % 8 == 5);
            if (line_idx % 16 == 7 && rem != 0) in_valid = 1'b1;

            // model of the coming clock edge
            exp_vld = 0;
            if (rem > 0) begin
                rem--;
                if (rem == 0) begin
                    exp_vld = 1;
                    cur_st = fl_st; cur_len = fl_len; cur_fits = fl_fits; cur_idx = fl_idx;
                end
            end else if (in_valid) begin
                rem = 5;
                fl_st = pd_st; fl_len = pd_len; fl_fits = pd_fits; fl_idx = line_idx;
                have_pend = 0;
                line_idx++;
            end

            if (line_idx >= NLINES && rem == 0 && !exp_vld && !have_pend) begin
                in_valid = 1'b0;
                done = 1;
            end
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog: run did not complete");
                done = 1;
            end
        end
        @(negedge clk);
        chk(!out_valid && in_ready, "R2", "idle at end", 576'(out_valid), 576'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule